// File: doc/BRIEF.md
# NOR Flash Program/Erase Sequencer

This block turns high-level flash requests into the byte-wide write and read cycles that a parallel NOR device expects. It issues the unlock-and-command writes for byte programming, page programming and three erase flavours (sector, block, whole chip). For programming it pulls data from a ready/valid source. It skips bytes that already hold the erased value. After a program step it hands control to an external completion poller, reads the written bytes back, and reissues the whole program sequence on a mismatch, up to a bounded number of retries.

A range write in page mode is cut at page boundaries. The page size is given as a power of two. Each page segment is loaded into a local buffer. The buffer is programmed after a single preamble and verified as a unit. The command-address mask is chosen per request, so devices that decode only 11 or 12 address bits can be served. A configurable idle gap, in clock cycles, follows every erase command write. Erase completion is delegated to the poller with the slow-polling hint raised.

Top module: `nor_cmd_engine`

## Requirements
- R1: A program attempt writes 0xAA at the masked address 0x5555, then 0x55 at masked 0x2AAA, then 0xA0 at masked 0x5555, and then the data byte(s) at the target. `mask_sel` encoding: 0 selects mask 0xFFFF, 1 selects 0x07FF, 2 selects 0x0FFF, 3 selects mask 0.
- R2: In byte mode (`cmd`=0), a source byte equal to 0xFF produces no bus cycle and no error. In any mode, no bus write ever carries the value 0xFF.
- R3: After each program attempt the target is read back and compared. On a mismatch the complete attempt is reissued, up to 16 retries (17 attempts in total), after which `fail` is reported. In byte mode the remaining bytes of the range are still processed.
- R4: Page mode (`cmd`=1) issues one preamble per attempt and then writes every non-0xFF byte of the segment in ascending address order. It then raises `poll_req` with `poll_addr` equal to the segment's last byte and `poll_slow`=0. It reads back every byte of the segment, and it retries the whole segment if any byte differs.
- R5: A page-mode range [addr, addr+len) is split so that each segment lies inside one page of 2^`pg_log2` bytes. Segments run from the higher of the range start and the page base to the lower of the range end and the next page base.
- R6: In page mode, a segment that still fails after its retries ends the request with `fail`. No later segment is loaded from the source or written.
- R7: An erase issues six writes: 0xAA@m5555, 0x55@m2AAA, 0x80@m5555, 0xAA@m5555, 0x55@m2AAA, then the erase code. The code is 0x30 at `addr` for a sector (`cmd`=2), 0x50 at `addr` for a block (`cmd`=3), or 0x10 at masked 0x5555 for the whole chip (`cmd`=4 and `cmd`=5).
- R8: After every erase command write the bus stays idle for GAP cycles, so consecutive erase writes are GAP+1 cycles apart. GAP=0 removes the gap. Erase completion is awaited with `poll_req` high, `poll_slow`=1 and `poll_addr`=0.
- R9: A whole-chip erase requested through the block path (`cmd`=5) proceeds only when `addr` is 0 and `len` equals 2^AW. Otherwise, as for codes 6 and 7, the request ends with `done` and `fail` and no bus cycle.
- R10: `busy` is high from the cycle after `start` until the end of the request. `done` is a one-cycle pulse at the end, with `fail` valid alongside it. A program request with `len`=0 completes without bus cycles and without `fail`.
- R11: `bus_we` and `bus_re` are never high together, and neither is high while `poll_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, accepted when idle |
| cmd | input | 3 | 0 byte program, 1 page program, 2 sector erase, 3 block erase, 4 chip erase, 5 chip erase via block path |
| addr | input | AW | Start or erase address |
| len | input | AW+1 | Byte count of the range (erase size for `cmd`=5) |
| pg_log2 | input | PLW | Page size exponent |
| mask_sel | input | 2 | Command-address mask selection |
| src_valid | input | 1 | Source byte available |
| src_data | input | 8 | Source byte |
| src_ready | output | 1 | Engine takes a source byte this cycle |
| bus_we | output | 1 | Flash write cycle |
| bus_re | output | 1 | Flash read cycle; data returns the next cycle |
| bus_addr | output | AW | Flash address |
| bus_wdata | output | 8 | Flash write data |
| bus_rdata | input | 8 | Flash read data |
| poll_req | output | 1 | Completion poll request, held until `poll_done` |
| poll_slow | output | 1 | Use the slow, widely spaced poll method |
| poll_addr | output | AW | Address the poller should watch |
| poll_done | input | 1 | Poller reports completion |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| fail | output | 1 | Request failed, valid with `done` |

## Verification
Four properties are checked on every cycle. `done` is a single-cycle pulse that closes each busy interval. Reads and writes never overlap and stay off the bus while a poll is pending. No write ever carries the erased value. Erase writes are followed by idle cycles whenever the gap is non-zero. The command sequences themselves can only be shown by the bench's scenarios, which log every bus write against a device model that injects programming faults. These include the mask variants, the retry count up to exhaustion, page segmentation, the stop after a failed page, and the rejection of a malformed chip erase.

// File: rtl/nor_cmd_engine.sv
module nor_cmd_engine #(
  parameter int AW      = 20,
  parameter int MAX_PG  = 256,
  parameter int GAP     = 4,
  parameter int RETRIES = 16,
  parameter int PLW     = $clog2($clog2(MAX_PG) + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [2:0]     cmd,
  input  logic [AW-1:0]  addr,
  input  logic [AW:0]    len,
  input  logic [PLW-1:0] pg_log2,
  input  logic [1:0]     mask_sel,
  input  logic           src_valid,
  input  logic [7:0]     src_data,
  output logic           src_ready,
  output logic           bus_we,
  output logic           bus_re,
  output logic [AW-1:0]  bus_addr,
  output logic [7:0]     bus_wdata,
  input  logic [7:0]     bus_rdata,
  output logic           poll_req,
  output logic           poll_slow,
  output logic [AW-1:0]  poll_addr,
  input  logic           poll_done,
  output logic           busy,
  output logic           done,
  output logic           fail
);
  localparam int PW = $clog2(MAX_PG);
  localparam int GW = (GAP > 1) ? $clog2(GAP) : 1;
  localparam int TW = $clog2(RETRIES + 1);
  localparam logic [AW:0] DEV = {1'b1, {AW{1'b0}}};

  typedef enum logic [3:0] {
    S_IDLE, S_SEG, S_LOAD, S_CMD, S_GAP, S_DATA, S_POLL, S_VRD, S_VCMP, S_NEXT, S_FIN
  } st_t;

  st_t            st;
  logic [2:0]     op, step;
  logic [1:0]     msel;
  logic [PLW-1:0] pgl;
  logic [AW-1:0]  ea;
  logic [AW:0]    cur, lim, seg;
  logic [PW:0]    segn, idx;
  logic [TW-1:0]  tries;
  logic [GW-1:0]  gcnt;
  logic           bad;
  logic [7:0]     buf_m [MAX_PG];

  logic [15:0]    mask;
  logic [AW-1:0]  a1, a2, cmd_a;
  logic [7:0]     cmd_d, buf_rd;
  logic [AW:0]    pg_end, seg_end, nxt;
  logic           is_erase, is_byte, last_step, seg_last_idx;

  always_comb begin
    case (msel)
      2'd0:    mask = 16'hFFFF;
      2'd1:    mask = 16'h07FF;
      2'd2:    mask = 16'h0FFF;
      default: mask = 16'h0000;
    endcase
  end

  assign a1       = AW'(16'h5555 & mask);
  assign a2       = AW'(16'h2AAA & mask);
  assign is_erase = op >= 3'd2;
  assign is_byte  = op == 3'd0;
  assign last_step = is_erase ? (step == 3'd5) : (step == 3'd2);
  assign pg_end   = ((cur >> pgl) + 1'b1) << pgl;
  assign seg_end  = (lim < pg_end) ? lim : pg_end;
  assign nxt      = seg + (AW+1)'(segn);
  assign buf_rd   = buf_m[idx[PW-1:0]];
  assign seg_last_idx = idx == segn - 1'b1;

  always_comb begin
    cmd_a = a1;
    cmd_d = 8'hAA;
    case (step)
      3'd1, 3'd4: begin cmd_a = a2; cmd_d = 8'h55; end
      3'd2:       cmd_d = is_erase ? 8'h80 : 8'hA0;
      3'd5: begin
        case (op)
          3'd2:    begin cmd_a = ea; cmd_d = 8'h30; end
          3'd3:    begin cmd_a = ea; cmd_d = 8'h50; end
          default: cmd_d = 8'h10;
        endcase
      end
      default: ;
    endcase
  end

  assign src_ready = st == S_LOAD;
  assign bus_we    = (st == S_CMD) || (st == S_DATA && buf_rd != 8'hFF);
  assign bus_re    = st == S_VRD;
  assign bus_addr  = (st == S_CMD) ? cmd_a : AW'(seg + (AW+1)'(idx));
  assign bus_wdata = (st == S_CMD) ? cmd_d : buf_rd;
  assign poll_req  = st == S_POLL;
  assign poll_slow = is_erase;
  assign poll_addr = (is_erase || is_byte) ? '0 : AW'(nxt - 1'b1);
  assign busy      = st != S_IDLE;
  assign done      = st == S_FIN;
  assign fail      = bad;

  always_ff @(posedge clk)
    if (st == S_LOAD && src_valid) buf_m[idx[PW-1:0]] <= src_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; op <= '0; step <= '0; msel <= '0; pgl <= '0; ea <= '0;
      cur <= '0; lim <= '0; seg <= '0; segn <= '0; idx <= '0;
      tries <= '0; gcnt <= '0; bad <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          op <= cmd; msel <= mask_sel; pgl <= pg_log2; ea <= addr;
          cur <= {1'b0, addr}; lim <= {1'b0, addr} + len;
          bad <= 1'b0; step <= '0; gcnt <= '0;
          if (cmd <= 3'd1)                             st <= (len == '0) ? S_FIN : S_SEG;
          else if (cmd <= 3'd4)                        st <= S_CMD;
          else if (cmd == 3'd5 && addr == '0 && len == DEV) st <= S_CMD;
          else begin bad <= 1'b1; st <= S_FIN; end
        end
        S_SEG: begin
          seg <= cur; idx <= '0; tries <= '0;
          segn <= is_byte ? (PW+1)'(1) : (PW+1)'(seg_end - cur);
          st <= S_LOAD;
        end
        S_LOAD: if (src_valid) begin
          if (seg_last_idx) begin
            idx <= '0; step <= '0;
            st <= (is_byte && src_data == 8'hFF) ? S_NEXT : S_CMD;
          end else idx <= idx + 1'b1;
        end
        S_CMD: begin
          if (is_erase && GAP > 0) begin
            gcnt <= '0; st <= S_GAP;
          end else if (last_step) begin
            idx <= '0; st <= is_erase ? S_POLL : S_DATA;
          end else step <= step + 1'b1;
        end
        S_GAP: begin
          if (gcnt == GW'(GAP - 1)) begin
            if (last_step) st <= S_POLL;
            else begin step <= step + 1'b1; st <= S_CMD; end
          end else gcnt <= gcnt + 1'b1;
        end
        S_DATA: if (seg_last_idx) st <= S_POLL; else idx <= idx + 1'b1;
        S_POLL: if (poll_done) begin
          idx <= '0;
          st <= is_erase ? S_FIN : S_VRD;
        end
        S_VRD: st <= S_VCMP;
        S_VCMP: begin
          if (bus_rdata != buf_rd) begin
            if (tries == TW'(RETRIES)) begin
              bad <= 1'b1; st <= is_byte ? S_NEXT : S_FIN;
            end else begin
              tries <= tries + 1'b1; step <= '0; st <= S_CMD;
            end
          end else if (seg_last_idx) st <= S_NEXT;
          else begin idx <= idx + 1'b1; st <= S_VRD; end
        end
        S_NEXT: if (nxt >= lim) st <= S_FIN; else begin cur <= nxt; st <= S_SEG; end
        S_FIN: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module nor_cmd_engine_chk #(parameter int GAP = 4) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       bus_we,
  input logic       bus_re,
  input logic [7:0] bus_wdata,
  input logic       poll_req,
  input logic       poll_slow
);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R10
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> $past(done));
  // R11
  bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(bus_we && bus_re));
  // R11
  poll_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) poll_req |-> (!bus_we && !bus_re));
  // R2
  no_ff_write_chk: assert property (@(posedge clk) disable iff (!rst_n) bus_we |-> bus_wdata != 8'hFF);
  // R8
  erase_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (GAP > 0 && poll_slow && bus_we) |=> !bus_we);
endmodule

bind nor_cmd_engine nor_cmd_engine_chk #(.GAP(GAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .bus_we(bus_we),
  .bus_re(bus_re), .bus_wdata(bus_wdata), .poll_req(poll_req), .poll_slow(poll_slow)
);

// File: tb/tb_nor_cmd_engine.sv
`timescale 1ns/1ps
module tb_nor_cmd_engine;
  localparam int AW  = 20;
  localparam int GAP = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, start, src_valid, src_ready, bus_we, bus_re, poll_req, poll_slow, poll_done;
  logic busy, done, fail;
  logic [2:0] cmd;
  logic [AW-1:0] addr, bus_addr, poll_addr;
  logic [AW:0] len;
  logic [3:0] pg_log2;
  logic [1:0] mask_sel;
  logic [7:0] src_data, bus_wdata, bus_rdata;

  nor_cmd_engine #(.AW(AW), .MAX_PG(256), .GAP(GAP), .RETRIES(16)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .addr(addr), .len(len),
    .pg_log2(pg_log2), .mask_sel(mask_sel), .src_valid(src_valid), .src_data(src_data),
    .src_ready(src_ready), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .poll_req(poll_req), .poll_slow(poll_slow),
    .poll_addr(poll_addr), .poll_done(poll_done), .busy(busy), .done(done), .fail(fail));

  int checks = 0, failures = 0;
  logic [7:0] mem [int unsigned];
  int wa[$], wd[$], pa[$], ps[$];
  longint wc[$];
  longint cyc = 0;
  int bad_addr = -1, bad_cnt = 0;
  bit pgm = 0;
  int h1 = 0, h2 = 0;
  logic [7:0] sq[$];
  int sidx = 0;
  int pcnt = 0;
  bit rfail;

  function automatic logic [7:0] rdm(int unsigned a);
    return mem.exists(a) ? mem[a] : 8'hFF;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (bus_re) begin bus_rdata <= rdm(int'(bus_addr)); pgm = 0; end
    if (bus_we) begin
      wa.push_back(int'(bus_addr)); wd.push_back(int'(bus_wdata)); wc.push_back(cyc);
      if (pgm) begin
        if (int'(bus_addr) == bad_addr && bad_cnt > 0) bad_cnt--;
        else mem[int'(bus_addr)] = rdm(int'(bus_addr)) & bus_wdata;
      end else if (bus_wdata == 8'hA0 && h1 == 8'h55 && h2 == 8'hAA) pgm = 1;
      h2 = h1; h1 = int'(bus_wdata);
    end
    if (src_ready && src_valid) sidx <= sidx + 1;
    if (poll_done) begin poll_done <= 1'b0; pcnt <= 0; end
    else if (poll_req) begin
      if (pcnt == 3) begin
        poll_done <= 1'b1; pa.push_back(int'(poll_addr)); ps.push_back(int'(poll_slow));
      end else pcnt <= pcnt + 1;
    end
  end

  always_comb begin
    src_valid = sidx < sq.size();
    src_data  = src_valid ? sq[sidx] : 8'h00;
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [2:0] c, input int a, input int l, input logic [1:0] m, input logic [3:0] pl);
    int n = 0;
    wa.delete(); wd.delete(); wc.delete(); pa.delete(); ps.delete();
    sidx = 0; pgm = 0;
    @(negedge clk);
    cmd = c; addr = AW'(a); len = (AW+1)'(l); mask_sel = m; pg_log2 = pl; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10", "busy after start", int'(busy), 1);
    while (!done && n < 20000) begin @(negedge clk); n++; end
    if (!done) begin chk("R10", "request watchdog", 0, 1); return; end
    rfail = fail;
    @(negedge clk);
    chk("R10", "done is one pulse", int'(done), 0);
    chk("R10", "idle after done", int'(busy), 0);
  endtask

  task automatic t_reset;
    chk("R10", "reset busy", int'(busy), 0);
    chk("R10", "reset done", int'(done), 0);
    chk("R11", "reset bus_we", int'(bus_we), 0);
    chk("R11", "reset src_ready", int'(src_ready), 0);
  endtask

  task automatic t_byte_basic;
    int hits = 0;
    mem.delete(); sq = '{8'h3C, 8'hFF, 8'h81};
    run(3'd0, 'h100, 3, 2'd0, 4'd0);
    chk("R1", "byte fail", int'(rfail), 0);
    chk("R2", "write count with skipped FF", wa.size(), 8);
    chk("R1", "w0 addr", wa[0], 'h5555); chk("R1", "w0 data", wd[0], 'hAA);
    chk("R1", "w1 addr", wa[1], 'h2AAA); chk("R1", "w1 data", wd[1], 'h55);
    chk("R1", "w2 addr", wa[2], 'h5555); chk("R1", "w2 data", wd[2], 'hA0);
    chk("R1", "w3 addr", wa[3], 'h100);  chk("R1", "w3 data", wd[3], 'h3C);
    chk("R1", "w7 addr", wa[7], 'h102);  chk("R1", "w7 data", wd[7], 'h81);
    foreach (wa[i]) if (wa[i] == 'h101) hits++;
    chk("R2", "no write to FF byte", hits, 0);
    chk("R3", "readback programmed", int'(rdm('h102)), 'h81);
  endtask

  task automatic t_mask;
    mem.delete(); sq = '{8'h12};
    run(3'd0, 'h40, 1, 2'd1, 4'd0);
    chk("R1", "mask1 first addr", wa[0], 'h555);
    chk("R1", "mask1 second addr", wa[1], 'h2AA);
    mem.delete(); sq = '{8'h12};
    run(3'd0, 'h40, 1, 2'd2, 4'd0);
    chk("R1", "mask2 second addr", wa[1], 'hAAA);
    mem.delete(); sq = '{8'h12};
    run(3'd0, 'h40, 1, 2'd3, 4'd0);
    chk("R1", "mask3 first addr", wa[0], 0);
    chk("R1", "mask3 data landed", int'(rdm('h40)), 'h12);
  endtask

  task automatic t_retry;
    mem.delete(); sq = '{8'h5A}; bad_addr = 'h200; bad_cnt = 2;
    run(3'd0, 'h200, 1, 2'd0, 4'd0);
    chk("R3", "retry recovers", int'(rfail), 0);
    chk("R3", "three attempts of four writes", wa.size(), 12);
    chk("R3", "data after retries", int'(rdm('h200)), 'h5A);
    mem.delete(); sq = '{8'h01, 8'h02}; bad_addr = 'h210; bad_cnt = 1000;
    run(3'd0, 'h210, 2, 2'd0, 4'd0);
    chk("R3", "exhausted retries fail", int'(rfail), 1);
    chk("R3", "17 attempts then next byte", wa.size(), 72);
    chk("R3", "next byte still programmed", int'(rdm('h211)), 'h02);
    bad_addr = -1; bad_cnt = 0;
  endtask

  task automatic t_page;
    mem.delete(); sq = '{8'h11, 8'hFF, 8'h22, 8'h33, 8'h44, 8'h55};
    run(3'd1, 'h205, 6, 2'd0, 4'd3);
    chk("R4", "page fail", int'(rfail), 0);
    chk("R5", "write count two segments", wa.size(), 11);
    chk("R4", "first data addr", wa[3], 'h205); chk("R4", "first data", wd[3], 'h11);
    chk("R4", "FF skipped in page", wa[4], 'h207);
    chk("R5", "second preamble", wd[7], 'hA0);
    chk("R5", "second segment start", wa[8], 'h208);
    chk("R5", "second segment end", wa[10], 'h20A);
    chk("R5", "poll count", pa.size(), 2);
    chk("R4", "poll at segment end", pa[0], 'h207);
    chk("R5", "poll at page end", pa[1], 'h20A);
    chk("R4", "poll fast", ps[0], 0);
    chk("R4", "source consumed", sidx, 6);
    mem.delete(); sq = '{8'hA1, 8'hA2, 8'hA3, 8'hA4}; bad_addr = 'h402; bad_cnt = 1;
    run(3'd1, 'h400, 4, 2'd0, 4'd2);
    chk("R4", "page retry recovers", int'(rfail), 0);
    chk("R4", "page rewritten whole", wa.size(), 14);
    chk("R4", "poll twice", pa.size(), 2);
    chk("R4", "retried byte", int'(rdm('h402)), 'hA3);
    bad_addr = -1; bad_cnt = 0;
  endtask

  task automatic t_page_stop;
    int late = 0;
    mem.delete(); sq = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08};
    bad_addr = 'h301; bad_cnt = 1000;
    run(3'd1, 'h300, 8, 2'd0, 4'd2);
    chk("R6", "range fail", int'(rfail), 1);
    chk("R6", "only first page attempts", wa.size(), 119);
    foreach (wa[i]) if (wa[i] >= 'h304 && wa[i] < 'h308) late++;
    chk("R6", "later page untouched", late, 0);
    chk("R6", "later page not loaded", sidx, 4);
    bad_addr = -1; bad_cnt = 0;
  endtask

  task automatic t_erase;
    int gap_bad = 0;
    run(3'd2, 'h1000, 0, 2'd0, 4'd0);
    chk("R7", "sector write count", wa.size(), 6);
    chk("R7", "sector w2", wd[2], 'h80);
    chk("R7", "sector w3", wd[3], 'hAA);
    chk("R7", "sector w4 addr", wa[4], 'h2AAA);
    chk("R7", "sector code", wd[5], 'h30);
    chk("R7", "sector addr", wa[5], 'h1000);
    for (int i = 0; i + 1 < wc.size(); i++) if (wc[i+1] - wc[i] != GAP + 1) gap_bad++;
    chk("R8", "gap between erase writes", gap_bad, 0);
    chk("R8", "slow poll", ps[0], 1);
    chk("R8", "poll at base", pa[0], 0);
    run(3'd3, 'h2000, 0, 2'd0, 4'd0);
    chk("R7", "block code", wd[5], 'h50);
    chk("R7", "block addr", wa[5], 'h2000);
    run(3'd4, 'h3000, 0, 2'd1, 4'd0);
    chk("R7", "chip code", wd[5], 'h10);
    chk("R7", "chip addr masked", wa[5], 'h555);
    chk("R7", "chip fail", int'(rfail), 0);
  endtask

  task automatic t_chipb;
    run(3'd5, 4, 1 << AW, 2'd0, 4'd0);
    chk("R9", "nonzero addr rejected", int'(rfail), 1);
    chk("R9", "no bus cycles", wa.size(), 0);
    run(3'd5, 0, 1 << (AW - 1), 2'd0, 4'd0);
    chk("R9", "short size rejected", int'(rfail), 1);
    run(3'd6, 0, 0, 2'd0, 4'd0);
    chk("R9", "unknown code rejected", int'(rfail), 1);
    run(3'd5, 0, 1 << AW, 2'd0, 4'd0);
    chk("R9", "valid accepted", int'(rfail), 0);
    chk("R9", "six writes", wa.size(), 6);
    chk("R9", "chip code at 5555", wa[5], 'h5555);
  endtask

  task automatic t_len0;
    run(3'd0, 'h50, 0, 2'd0, 4'd0);
    chk("R10", "zero length no fail", int'(rfail), 0);
    chk("R10", "zero length no writes", wa.size(), 0);
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; cmd = '0; addr = '0; len = '0; pg_log2 = '0; mask_sel = '0;
    poll_done = 1'b0; bus_rdata = 8'hFF;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_byte_basic();
    t_mask();
    t_retry();
    t_page();
    t_page_stop();
    t_erase();
    t_chipb();
    t_len0();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule